// File: doc/BRIEF.md
# Programmable Periodic Timebase Interrupt Unit

This block turns the oscillator clock into a periodic timeout event. A free-running prescaler counts oscillator cycles up to one of four programmable limits. Each time the limit is reached the block emits a one-cycle tick, sets a sticky flag and, when enabled and not globally masked, raises an interrupt request. Software reaches a single 8-bit control/status register through a simple byte bus. Writing it picks the period and the interrupt enable. Reading it returns the state and clears the flag.

A new period choice never cuts the running period short. The counter finishes the period in progress and adopts the new choice only at its wrap, so a chain of ticks can serve as a real-time reference. The block also tracks the power mode. In wait and active-halt the counter keeps running and an interrupt request returns the system to run. In full halt the counter and register freeze until an external wake. A halt request issued while the enable bit is set becomes an active-halt instead of a full halt.

Top module: `periodic_tick_unit`

## Requirements
- R1: After reset the register reads 00h, `irq_o` and `tick_o` are low, and `mode_o` is 0 (run).
- R2: With period select value s in register bits 3:2, consecutive ticks are exactly PERIOD_SELs clock cycles apart (defaults: 0→16000, 1→32000, 2→80000, 3→200000).
- R3: A select written in the middle of a period takes effect only at the next wrap. The period in progress keeps its old length and the following period uses the new one.
- R4: The cycle after a tick, bit 0 (flag) of the register reads 1. A register read returns the value before any clear, and it clears the flag.
- R5: If a tick and a register read fall in the same cycle, the flag is set afterwards.
- R6: `irq_o` is high exactly when the flag (bit 0), the enable (bit 1) and a low `irq_mask_i` are all present.
- R7: A write updates only bits 3:1. Bits 7:4 always read 0, and the written bit 0 has no effect on the flag.
- R8: A wait request in run mode gives `mode_o` = 1 (wait). The counter keeps running, and an active `irq_o` or `wake_i` returns the mode to 0 the next cycle.
- R9: A halt request in run mode with the enable bit set gives `mode_o` = 2 (active-halt). Ticks continue, and an active `irq_o` or `wake_i` returns the mode to 0.
- R10: A halt request with the enable bit clear gives `mode_o` = 3 (full halt). No tick occurs, bus reads and writes are ignored, and the counter holds its value. Only `wake_i` returns the mode to 0, and counting then resumes from the held value.
- R11: When a halt request and a wait request arrive in the same run cycle, the halt request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read (with `bus_sel`) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents {0000, select[1:0], enable, flag} |
| irq_mask_i | input | 1 | Global interrupt mask, 1 = masked |
| wait_req_i | input | 1 | Request to enter wait mode |
| halt_req_i | input | 1 | Request to enter a halt mode |
| wake_i | input | 1 | External wake event |
| irq_o | output | 1 | Interrupt request |
| tick_o | output | 1 | One-cycle timeout pulse |
| mode_o | output | 2 | Power mode: 0 run, 1 wait, 2 active-halt, 3 full halt |

## Verification
The bench builds the unit with periods of 6, 9, 14 and 23 cycles instead of the tens of thousands used by default. This makes every one of the sixteen old-to-new select transitions cheap to sweep, each with both the in-progress period and the following period measured. The short periods also allow all eight flag/enable/mask combinations to be placed right after a tick. The halt-freeze case can then be timed to the exact cycle of resumption from the held count.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_WAIT  = 2'd1,
        PM_AHALT = 2'd2,
        PM_HALT  = 2'd3
    } pmode_e;

    // Layout of the low nibble of the control/status byte
    localparam int FLAG_BIT = 0;
    localparam int IE_BIT   = 1;
    localparam int SEL_LO   = 2;
    localparam int SEL_HI   = 3;
    localparam int SEL_W    = 2;
    localparam int NUM_SEL  = 1 << SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ie;
        logic             flag;
    } csr_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_pkg::*;
#(
    parameter int unsigned PER0  = 16000,
    parameter int unsigned PER1  = 32000,
    parameter int unsigned PER2  = 80000,
    parameter int unsigned PER3  = 200000,
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_req_i,
    output logic             tick_o
);
    localparam int unsigned LIM [NUM_SEL] = '{PER0 - 1, PER1 - 1, PER2 - 1, PER3 - 1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } pre_t;

    pre_t st_d, st_q;
    logic [NUM_SEL-1:0] term_hit;
    logic wrap;

    // One terminal-count comparator per selectable period
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
        assign term_hit[g] = (st_q.cnt == CNT_W'(LIM[g]));
    end

    assign wrap   = run_i & term_hit[st_q.sel];
    assign tick_o = wrap;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (wrap) begin
                st_d.cnt = '0;
                st_d.sel = sel_req_i;   // deferred period change lands here
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tick_csr.sv
module tick_csr
    import tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen_i,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    input  logic             tick_i,
    input  logic             irq_mask_i,
    output logic [7:0]       rdata_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             ie_o,
    output logic             irq_o
);
    csr_t st_d, st_q;
    logic rd_hit, wr_hit;

    assign rd_hit = bus_sel & ~bus_wr & ~frozen_i;
    assign wr_hit = bus_sel &  bus_wr & ~frozen_i;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.sel = bus_wdata[SEL_HI:SEL_LO];
            st_d.ie  = bus_wdata[IE_BIT];
        end
        if (rd_hit) st_d.flag = 1'b0;
        if (tick_i) st_d.flag = 1'b1;     // a fresh timeout beats the read clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = {4'b0000, st_q};
    assign sel_o   = st_q.sel;
    assign ie_o    = st_q.ie;
    assign irq_o   = st_q.flag & st_q.ie & ~irq_mask_i;

endmodule

// File: rtl/tick_power.sv
module tick_power
    import tick_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wait_req_i,
    input  logic   halt_req_i,
    input  logic   wake_i,
    input  logic   ie_i,
    input  logic   irq_i,
    output pmode_e mode_o,
    output logic   run_o
);
    pmode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            PM_RUN: begin
                if (halt_req_i)      mode_d = ie_i ? PM_AHALT : PM_HALT;
                else if (wait_req_i) mode_d = PM_WAIT;
            end
            PM_WAIT, PM_AHALT: begin
                if (irq_i || wake_i) mode_d = PM_RUN;
            end
            PM_HALT: begin
                if (wake_i) mode_d = PM_RUN;
            end
            default: mode_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= PM_RUN;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;
    assign run_o  = (mode_q != PM_HALT);

endmodule

// File: rtl/periodic_tick_unit.sv
module periodic_tick_unit
    import tick_pkg::*;
#(
    parameter int unsigned PERIOD_SEL0 = 16000,
    parameter int unsigned PERIOD_SEL1 = 32000,
    parameter int unsigned PERIOD_SEL2 = 80000,
    parameter int unsigned PERIOD_SEL3 = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_mask_i,
    input  logic       wait_req_i,
    input  logic       halt_req_i,
    input  logic       wake_i,
    output logic       irq_o,
    output logic       tick_o,
    output logic [1:0] mode_o
);
    localparam int unsigned MAX01 = (PERIOD_SEL0 > PERIOD_SEL1) ? PERIOD_SEL0 : PERIOD_SEL1;
    localparam int unsigned MAX23 = (PERIOD_SEL2 > PERIOD_SEL3) ? PERIOD_SEL2 : PERIOD_SEL3;
    localparam int unsigned MAXP  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned CNT_W = (MAXP > 2) ? $clog2(MAXP) : 1;

    logic             run;
    logic             tick;
    logic [SEL_W-1:0] sel_req;
    logic             ie;
    logic             irq;
    pmode_e           mode;

    tick_prescaler #(
        .PER0 (PERIOD_SEL0),
        .PER1 (PERIOD_SEL1),
        .PER2 (PERIOD_SEL2),
        .PER3 (PERIOD_SEL3),
        .CNT_W(CNT_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .sel_req_i(sel_req),
        .tick_o   (tick)
    );

    tick_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frozen_i  (~run),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .tick_i    (tick),
        .irq_mask_i(irq_mask_i),
        .rdata_o   (bus_rdata),
        .sel_o     (sel_req),
        .ie_o      (ie),
        .irq_o     (irq)
    );

    tick_power u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_req_i(wait_req_i),
        .halt_req_i(halt_req_i),
        .wake_i    (wake_i),
        .ie_i      (ie),
        .irq_i     (irq),
        .mode_o    (mode),
        .run_o     (run)
    );

    assign irq_o  = irq;
    assign tick_o = tick;
    assign mode_o = mode;

endmodule

// File: rtl/tick_unit_checker.sv
module tick_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       irq_mask_i,
    input logic       wait_req_i,
    input logic       halt_req_i,
    input logic       irq_o,
    input logic       tick_o,
    input logic [1:0] mode_o
);
    a_r4_flag_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> bus_rdata[0]);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !tick_o && mode_o != 2'd3) |=> !bus_rdata[0]);

    a_r5_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && bus_sel && !bus_wr) |=> bus_rdata[0]);

    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (bus_rdata[0] && bus_rdata[1] && !irq_mask_i));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:4] == 4'h0);

    a_r9_active_halt_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && halt_req_i && bus_rdata[1]) |=> mode_o == 2'd2);

    a_r10_no_tick_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> !tick_o);

    a_r10_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |=> $stable(bus_rdata));

    a_r11_halt_over_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && halt_req_i && wait_req_i && !bus_rdata[1]) |=> mode_o == 2'd3);

endmodule

bind periodic_tick_unit tick_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq_mask_i(irq_mask_i),
    .wait_req_i(wait_req_i),
    .halt_req_i(halt_req_i),
    .irq_o     (irq_o),
    .tick_o    (tick_o),
    .mode_o    (mode_o)
);

// File: tb/tb_periodic_tick_unit.sv
`timescale 1ns/1ps
module tb_periodic_tick_unit;
    localparam int P0 = 6, P1 = 9, P2 = 14, P3 = 23;
    int per [4] = '{P0, P1, P2, P3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_mask_i = 1'b0, wait_req_i = 1'b0, halt_req_i = 1'b0, wake_i = 1'b0;
    logic       irq_o, tick_o;
    logic [1:0] mode_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    periodic_tick_unit #(
        .PERIOD_SEL0(P0), .PERIOD_SEL1(P1), .PERIOD_SEL2(P2), .PERIOD_SEL3(P3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_mask_i(irq_mask_i),
        .wait_req_i(wait_req_i), .halt_req_i(halt_req_i), .wake_i(wake_i),
        .irq_o(irq_o), .tick_o(tick_o), .mode_o(mode_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // All tasks start and end on a falling edge
    task automatic bus_write(input logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_o && n < 500);
        if (n >= 500) chk("tick timeout", n, 0);
    endtask

    // Measures one gap and writes v in its third cycle
    task automatic gap_with_write(input logic [7:0] v, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 2) begin bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v; end
            if (n == 3) begin bus_sel = 1'b0; bus_wr = 1'b0; end
        end while (!tick_o && n < 500);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=1 expected=0");
        fails++;
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int n;
        int ticks_seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", irq_o, 0);
        chk("R1 tick", tick_o, 0);
        chk("R1 mode", mode_o, 0);
        @(negedge clk);

        // R2 / R3: sweep every old->new select pair
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                bus_write(8'(f << 2));
                wait_tick(n);
                wait_tick(n);
                chk($sformatf("R2 period sel=%0d", f), n, per[f]);
                gap_with_write(8'(t << 2), n);
                chk($sformatf("R3 old period kept %0d->%0d", f, t), n, per[f]);
                wait_tick(n);
                chk($sformatf("R3 new period used %0d->%0d", f, t), n, per[t]);
            end
        end
        // Active select is now 3; go back to select 0
        bus_write(8'h00);
        wait_tick(n);
        wait_tick(n);
        chk("R2 period sel=0 again", n, P0);

        // R4: flag set after tick, read returns it, then cleared
        wait_tick(n);
        @(negedge clk);
        bus_read(rv);
        chk("R4 read shows flag", rv, 8'h01);
        bus_read(rv);
        chk("R4 flag cleared by read", rv, 8'h00);

        // R5: read in the tick cycle does not lose the event
        wait_tick(n);
        bus_read(rv);
        bus_read(rv);
        chk("R5 flag survives same-cycle read", rv[0], 1);
        bus_read(rv);
        chk("R5 later read clears", rv[0], 0);

        // R7: only bits 3:1 are writable
        wait_tick(n);
        bus_write(8'hFF);
        bus_read(rv);
        chk("R7 write FF readback with flag", rv, 8'h0F);
        bus_read(rv);
        chk("R7 write FF readback cleared", rv, 8'h0E);
        wait_tick(n);
        @(negedge clk);
        bus_read(rv);
        bus_write(8'hF1);
        bus_read(rv);
        chk("R7 write F1 ignores bit0 and 7:4", rv, 8'h00);
        // Select 3 was pending and landed at the last wrap; restore select 0
        bus_write(8'h00);
        wait_tick(n);
        wait_tick(n);
        chk("R7 restore sel=0", n, P0);

        // R6: all flag/enable/mask combinations
        for (int ie = 0; ie < 2; ie++) begin
            for (int mk = 0; mk < 2; mk++) begin
                for (int fl = 0; fl < 2; fl++) begin
                    irq_mask_i = 1'(mk);
                    wait_tick(n);
                    bus_write(8'(ie << 1));
                    if (fl == 0) bus_read(rv);
                    #1;
                    chk($sformatf("R6 irq ie=%0d mask=%0d flag=%0d", ie, mk, fl),
                        irq_o, ie & fl & (1 - mk));
                    @(negedge clk);
                end
            end
        end
        irq_mask_i = 1'b0;

        // R8: wait mode, counter keeps running, irq exits
        bus_write(8'h02);
        wait_tick(n);
        @(negedge clk);
        bus_read(rv);
        wait_req_i = 1'b1;
        @(negedge clk);
        wait_req_i = 1'b0;
        chk("R8 entered wait", mode_o, 1);
        wait_tick(n);
        chk("R8 tick while waiting", mode_o, 1);
        @(negedge clk);
        chk("R8 irq raised", irq_o, 1);
        chk("R8 still waiting", mode_o, 1);
        @(negedge clk);
        chk("R8 irq exits wait", mode_o, 0);

        // R9: active-halt, ticks continue, masked irq keeps it, unmask exits
        irq_mask_i = 1'b1;
        wait_tick(n);
        @(negedge clk);
        bus_read(rv);
        halt_req_i = 1'b1;
        @(negedge clk);
        halt_req_i = 1'b0;
        chk("R9 enable turns halt into active-halt", mode_o, 2);
        wait_tick(n);
        chk("R9 tick in active-halt", (n <= P0) ? 1 : 0, 1);
        @(negedge clk);
        chk("R9 masked irq stays", mode_o, 2);
        irq_mask_i = 1'b0;
        @(negedge clk);
        chk("R9 irq exits active-halt", mode_o, 0);

        // R10: full halt freezes counter and register
        bus_write(8'h00);
        wait_tick(n);
        repeat (2) @(negedge clk);
        halt_req_i = 1'b1;
        @(negedge clk);
        halt_req_i = 1'b0;
        chk("R10 full halt entered", mode_o, 3);
        ticks_seen = 0;
        for (int k = 0; k < 40; k++) begin
            if (tick_o) ticks_seen++;
            if (k == 5) bus_write(8'h0E);
            else if (k == 10) bus_read(rv);
            else @(negedge clk);
        end
        chk("R10 no tick in halt", ticks_seen, 0);
        chk("R10 timeout cannot exit halt", mode_o, 3);
        wake_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            wake_i = 1'b0;
            if (n == 1) begin
                #1;
                chk("R10 wake returns to run", mode_o, 0);
                chk("R10 bus ignored while halted", bus_rdata, 8'h01);
            end
        end while (!tick_o && n < 500);
        chk("R10 resumes from held count", n, P0 - 2);

        // R11: halt beats wait
        @(negedge clk);
        halt_req_i = 1'b1;
        wait_req_i = 1'b1;
        @(negedge clk);
        halt_req_i = 1'b0;
        wait_req_i = 1'b0;
        chk("R11 halt wins over wait", mode_o, 3);
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
        chk("R11 wake exits", mode_o, 0);

        summary();
        $finish;
    end

endmodule